// File: doc/BRIEF.md
# ADC Input Level Detector

This block watches a stream of 14-bit two's-complement ADC samples. It measures their level over a window whose length the host sets, as a power of two counted in valid samples. Depending on the mode input, the measurement is either the largest sample magnitude seen or the mean of the squared samples. At the end of each window the result is written to a level register that the host can read, and the block pulses a one-cycle valid strobe.

The same update also steps a 3-bit gain code for an external variable-gain amplifier. Each code step stands for 6 dB of attenuation. The code moves at most one step per window and has a hysteresis band between a high and a low threshold, so it does not chatter. An overrange flag raised on any valid sample of the window sends the code straight to full attenuation.

Top module: `lvl_det`

## Requirements
- R1: After reset, `level_o` is 0, `level_vld_o` is 0 and `gain_code_o` is 0.
- R2: A window spans exactly 2^`win_log_i` cycles that have `sample_vld_i` high. Cycles with `sample_vld_i` low do not count. `level_vld_o` is high for exactly the one cycle that follows the clock edge taking the last sample of a window.
- R3: With `mode_i`=0 (peak), the level is the largest absolute sample value in the window. A sample of -8192 gives 8192.
- R4: With `mode_i`=1 (mean), the level is floor(sum of squared samples / 2^`win_log_i`).
- R5: `level_o` holds its value between updates. Each window starts from a cleared peak hold and a cleared accumulator, so no earlier sample affects its result.
- R6: On an update where the level is greater than `thr_hi_i`, the gain code rises by one, saturating at 7. The code appears one cycle after `level_vld_o`.
- R7: On an update where the level is less than `thr_lo_i`, the gain code falls by one, saturating at 0. A level from `thr_lo_i` to `thr_hi_i` inclusive leaves the code unchanged.
- R8: If `ovr_i` is high on any cycle of the window that also has `sample_vld_i` high, that update sets the gain code to 7 whatever the level. `ovr_i` on a cycle without a valid sample is ignored.
- R9: `mode_i` and `win_log_i` are captured with the first sample of a window. Changes during a window take effect only from the next window.
- R10: The gain code changes only in the cycle after a `level_vld_o` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | 14 | Signed ADC sample |
| sample_vld_i | input | 1 | Sample strobe |
| ovr_i | input | 1 | ADC overrange flag |
| mode_i | input | 1 | 0 = peak, 1 = mean power |
| win_log_i | input | 4 | log2 of window length, clipped to 10 |
| thr_hi_i | input | 28 | Upper hysteresis threshold |
| thr_lo_i | input | 28 | Lower hysteresis threshold |
| level_o | output | 28 | Latched measurement |
| level_vld_o | output | 1 | One-cycle update pulse |
| gain_code_o | output | 3 | Attenuation code, 6 dB per step |

## Verification
The hardest situation to reach from the ports is a mode or window-length change that arrives partway through a window. The stimulus starts a two-sample peak window, then switches to a four-sample mean window together with the second sample. It expects a peak result after those two samples.

A second hard case is an overrange flag raised on a cycle with no valid sample. The bench raises it between windows and then checks that the gain code follows only the hysteresis rule. Gaps of invalid cycles inside some table windows show that window counting ignores idle cycles.

// File: rtl/lvl_det_pkg.sv
package lvl_det_pkg;
  typedef enum logic {MODE_PEAK = 1'b0, MODE_MEAN = 1'b1} meas_mode_e;
  localparam int CODE_W = 3;
  localparam logic [CODE_W-1:0] CODE_MAX = '1;
endpackage

// File: rtl/lvl_win_ctr.sv
module lvl_win_ctr
  import lvl_det_pkg::*;
#(
  parameter int WIN_LOG_MAX = 10,
  parameter int WL_W = $clog2(WIN_LOG_MAX + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  meas_mode_e      mode_i,
  input  logic [WL_W-1:0] win_log_i,
  output meas_mode_e      mode_o,
  output logic [WL_W-1:0] shift_o,
  output logic            last_o
);
  localparam int CNT_W = (WIN_LOG_MAX > 0) ? WIN_LOG_MAX : 1;

  logic             fresh_q;
  meas_mode_e       mode_q;
  logic [WL_W-1:0]  wl_q;
  logic [CNT_W-1:0] cnt_q;
  logic [WL_W-1:0]  wl_clip;
  logic [CNT_W-1:0] term;

  assign wl_clip = (win_log_i > WL_W'(WIN_LOG_MAX)) ? WL_W'(WIN_LOG_MAX) : win_log_i;
  // config is taken from the ports only on the first sample of a window
  assign mode_o  = fresh_q ? mode_i : mode_q;
  assign shift_o = fresh_q ? wl_clip : wl_q;
  assign term    = (CNT_W'(1) << shift_o) - CNT_W'(1);
  assign last_o  = valid_i && (cnt_q == term);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fresh_q <= 1'b1;
      mode_q  <= MODE_PEAK;
      wl_q    <= '0;
      cnt_q   <= '0;
    end else if (valid_i) begin
      if (fresh_q) begin
        mode_q <= mode_i;
        wl_q   <= wl_clip;
      end
      if (last_o) begin
        cnt_q   <= '0;
        fresh_q <= 1'b1;
      end else begin
        cnt_q   <= cnt_q + CNT_W'(1);
        fresh_q <= 1'b0;
      end
    end
  end

  AST_FRESH_CNT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fresh_q |-> cnt_q == '0); // R2
  AST_CNT_IN_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fresh_q |-> cnt_q <= term); // R2
  AST_CFG_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fresh_q |=> $stable(wl_q) && $stable(mode_q)); // R9
endmodule

// File: rtl/lvl_meas.sv
module lvl_meas
  import lvl_det_pkg::*;
#(
  parameter int DATA_W = 14,
  parameter int WIN_LOG_MAX = 10,
  parameter int WL_W = $clog2(WIN_LOG_MAX + 1),
  parameter int RES_W = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] sample_i,
  input  logic              ovr_i,
  input  meas_mode_e        mode_i,
  input  logic [WL_W-1:0]   shift_i,
  input  logic              last_i,
  output logic [RES_W-1:0]  level_o,
  output logic              vld_o,
  output logic              ovr_win_o
);
  localparam int ACC_W = RES_W + WIN_LOG_MAX;

  logic [DATA_W-1:0] mag, peak_q, peak_nxt;
  logic [RES_W-1:0]  sq, fin;
  logic [ACC_W-1:0]  acc_q, acc_nxt;
  logic              ovr_q, ovr_nxt;

  // two's-complement magnitude; the most negative code maps to 2^(DATA_W-1)
  assign mag      = sample_i[DATA_W-1] ? (~sample_i + DATA_W'(1)) : sample_i;
  assign sq       = RES_W'(mag) * RES_W'(mag);
  assign acc_nxt  = acc_q + ACC_W'(sq);
  assign peak_nxt = (mag > peak_q) ? mag : peak_q;
  assign ovr_nxt  = ovr_q | ovr_i;
  assign fin      = (mode_i == MODE_PEAK) ? RES_W'(peak_nxt) : RES_W'(acc_nxt >> shift_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q     <= '0;
      peak_q    <= '0;
      ovr_q     <= 1'b0;
      level_o   <= '0;
      vld_o     <= 1'b0;
      ovr_win_o <= 1'b0;
    end else begin
      vld_o <= 1'b0;
      if (valid_i) begin
        if (last_i) begin
          level_o   <= fin;
          vld_o     <= 1'b1;
          ovr_win_o <= ovr_nxt;
          acc_q     <= '0;
          peak_q    <= '0;
          ovr_q     <= 1'b0;
        end else begin
          acc_q  <= acc_nxt;
          peak_q <= peak_nxt;
          ovr_q  <= ovr_nxt;
        end
      end
    end
  end

  AST_LEVEL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_i && last_i) |=> $stable(level_o)); // R5
  AST_PEAK_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    peak_q <= DATA_W'(1) << (DATA_W - 1)); // R3
  AST_CLEAR_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && last_i |=> acc_q == '0 && peak_q == '0 && !ovr_q); // R5
endmodule

// File: rtl/lvl_gain_ctl.sv
module lvl_gain_ctl
  import lvl_det_pkg::*;
#(
  parameter int RES_W = 28
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_i,
  input  logic              ovr_i,
  input  logic [RES_W-1:0]  level_i,
  input  logic [RES_W-1:0]  thr_hi_i,
  input  logic [RES_W-1:0]  thr_lo_i,
  output logic [CODE_W-1:0] code_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_o <= '0;
    end else if (upd_i) begin
      if (ovr_i) code_o <= CODE_MAX;
      else if (level_i > thr_hi_i && code_o != CODE_MAX) code_o <= code_o + CODE_W'(1);
      else if (level_i < thr_lo_i && code_o != '0) code_o <= code_o - CODE_W'(1);
    end
  end

  AST_OVR_FULL_ATTEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i && ovr_i |=> code_o == CODE_MAX); // R8
  AST_CODE_ONLY_ON_UPD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> $stable(code_o)); // R10
  AST_ONE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i && !ovr_i |=> (CODE_W'(code_o - $past(code_o)) inside {3'd0, 3'd1, 3'd7})); // R7
  AST_BAND_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i && !ovr_i && level_i <= thr_hi_i && level_i >= thr_lo_i |=> $stable(code_o)); // R7
endmodule

// File: rtl/lvl_det.sv
module lvl_det
  import lvl_det_pkg::*;
#(
  parameter int DATA_W = 14,
  parameter int WIN_LOG_MAX = 10,
  parameter int WL_W = $clog2(WIN_LOG_MAX + 1),
  parameter int RES_W = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] sample_i,
  input  logic              sample_vld_i,
  input  logic              ovr_i,
  input  logic              mode_i,
  input  logic [WL_W-1:0]   win_log_i,
  input  logic [RES_W-1:0]  thr_hi_i,
  input  logic [RES_W-1:0]  thr_lo_i,
  output logic [RES_W-1:0]  level_o,
  output logic              level_vld_o,
  output logic [2:0]        gain_code_o
);
  meas_mode_e      eff_mode;
  logic [WL_W-1:0] eff_shift;
  logic            last;
  logic            ovr_win;

  lvl_win_ctr #(.WIN_LOG_MAX(WIN_LOG_MAX), .WL_W(WL_W)) u_win (
    .clk_i, .rst_ni,
    .valid_i  (sample_vld_i),
    .mode_i   (meas_mode_e'(mode_i)),
    .win_log_i,
    .mode_o   (eff_mode),
    .shift_o  (eff_shift),
    .last_o   (last)
  );

  lvl_meas #(.DATA_W(DATA_W), .WIN_LOG_MAX(WIN_LOG_MAX), .WL_W(WL_W), .RES_W(RES_W)) u_meas (
    .clk_i, .rst_ni,
    .valid_i   (sample_vld_i),
    .sample_i,
    .ovr_i,
    .mode_i    (eff_mode),
    .shift_i   (eff_shift),
    .last_i    (last),
    .level_o,
    .vld_o     (level_vld_o),
    .ovr_win_o (ovr_win)
  );

  lvl_gain_ctl #(.RES_W(RES_W)) u_gain (
    .clk_i, .rst_ni,
    .upd_i    (level_vld_o),
    .ovr_i    (ovr_win),
    .level_i  (level_o),
    .thr_hi_i,
    .thr_lo_i,
    .code_o   (gain_code_o)
  );
endmodule

// File: tb/lvl_det_test.sv
`timescale 1ns/1ps
module lvl_det_test;
  localparam logic [27:0] HI = 28'd1000;
  localparam logic [27:0] LO = 28'd100;

  typedef struct packed {
    logic              mode;
    logic [1:0]        wl;
    logic              ovr;
    logic              gap;
    logic signed [13:0] s0, s1, s2, s3;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'd2, 1'b0, 1'b0, 14'sd5, -14'sd1200, 14'sd30, 14'sd7},
    '{1'b0, 2'd1, 1'b0, 1'b1, 14'sd2000, 14'sd3, 14'sd0, 14'sd0},
    '{1'b1, 2'd2, 1'b0, 1'b0, 14'sd10, -14'sd10, 14'sd10, -14'sd10},
    '{1'b1, 2'd1, 1'b0, 1'b1, 14'sd4, -14'sd6, 14'sd0, 14'sd0},
    '{1'b0, 2'd0, 1'b0, 1'b0, 14'sd0, 14'sd0, 14'sd0, 14'sd0},
    '{1'b0, 2'd0, 1'b0, 1'b0, -14'sd3, 14'sd0, 14'sd0, 14'sd0},
    '{1'b0, 2'd2, 1'b0, 1'b1, 14'sd9, -14'sd8192, 14'sd100, 14'sd0},
    '{1'b1, 2'd2, 1'b0, 1'b0, 14'sd8191, 14'sd8191, 14'sd8191, 14'sd8191},
    '{1'b0, 2'd1, 1'b1, 1'b0, 14'sd1, 14'sd1, 14'sd0, 14'sd0},
    '{1'b0, 2'd1, 1'b0, 1'b0, 14'sd5000, 14'sd5000, 14'sd0, 14'sd0},
    '{1'b1, 2'd0, 1'b0, 1'b0, 14'sd40, 14'sd0, 14'sd0, 14'sd0},
    '{1'b1, 2'd2, 1'b0, 1'b1, 14'sd1, 14'sd2, 14'sd3, 14'sd4}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [13:0] sample = '0;
  logic        svld = 1'b0;
  logic        ovr = 1'b0;
  logic        mode = 1'b0;
  logic [3:0]  wl = '0;
  logic [27:0] level;
  logic        lvld;
  logic [2:0]  code;

  int n_chk = 0;
  int n_fail = 0;
  int exp_code = 0;

  always #2.5 clk = ~clk;

  lvl_det uut (
    .clk_i(clk), .rst_ni(rst_n), .sample_i(sample), .sample_vld_i(svld), .ovr_i(ovr),
    .mode_i(mode), .win_log_i(wl), .thr_hi_i(HI), .thr_lo_i(LO),
    .level_o(level), .level_vld_o(lvld), .gain_code_o(code)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic void model_code(input longint lv, input bit ov);
    if (ov) exp_code = 7;
    else if (lv > longint'(HI) && exp_code < 7) exp_code++;
    else if (lv < longint'(LO) && exp_code > 0) exp_code--;
  endfunction

  // After the last sample has been driven: check pulse and level, then the code.
  task automatic finish_window(input longint exp_lvl, input bit ov, input string req);
    @(negedge clk);
    svld = 1'b0;
    ovr  = 1'b0;
    check(lvld == 1'b1, "R2", longint'(lvld), 1);
    check(longint'(level) == exp_lvl, req, longint'(level), exp_lvl);
    model_code(exp_lvl, ov);
    @(negedge clk);
    check(lvld == 1'b0, "R2", longint'(lvld), 0);
    check(int'(code) == exp_code, ov ? "R8" : "R6/R7", longint'(code), exp_code);
  endtask

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(level == '0, "R1", longint'(level), 0);
    check(lvld == 1'b0, "R1", longint'(lvld), 0);
    check(code == '0, "R1", longint'(code), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      automatic vec_t t = VECS[v];
      automatic int n = 1 << t.wl;
      automatic logic signed [13:0] s [4] = '{t.s0, t.s1, t.s2, t.s3};
      automatic longint pk = 0;
      automatic longint sum = 0;
      automatic longint lv;
      for (int i = 0; i < n; i++) begin
        automatic longint a = (s[i] < 0) ? -longint'(s[i]) : longint'(s[i]);
        if (a > pk) pk = a;
        sum += a * a;
      end
      lv = t.mode ? (sum >> t.wl) : pk;
      for (int i = 0; i < n; i++) begin
        if (i > 0) @(negedge clk);
        if (t.gap && i > 0) begin
          svld = 1'b0;
          @(negedge clk);
          check(lvld == 1'b0, "R2", longint'(lvld), 0); // gap must not end window
        end
        svld   = 1'b1;
        sample = s[i];
        ovr    = t.ovr && (i == 0);
        mode   = t.mode;
        wl     = 4'(t.wl);
      end
      finish_window(lv, t.ovr, t.mode ? "R4" : "R3");
    end

    // R9: config changes mid-window are deferred
    svld = 1'b1; sample = 14'sd50; mode = 1'b0; wl = 4'd1;
    @(negedge clk);
    svld = 1'b1; sample = -14'sd70; mode = 1'b1; wl = 4'd2;
    finish_window(70, 1'b0, "R9");

    // R8: overrange without a valid sample is ignored
    svld = 1'b0; ovr = 1'b1;
    @(negedge clk);
    svld = 1'b1; ovr = 1'b0; sample = 14'sd10; mode = 1'b0; wl = 4'd0;
    finish_window(10, 1'b0, "R8");

    // R5/R10: idle cycles hold level and code
    repeat (5) @(negedge clk);
    check(longint'(level) == 10, "R5", longint'(level), 10);
    check(lvld == 1'b0, "R5", longint'(lvld), 0);
    check(int'(code) == exp_code, "R10", longint'(code), exp_code);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule